// File: doc/BRIEF.md
# Pending vector scan engine

This block is a hardware sequencer that drains the pending-message state of one group of a message termination bank. Two register levels hold that state. A summary register has one bit for each index register, and that bit is set while the index register holds any pending bit. Each index register holds one pending bit per message slot and clears itself when it is read. When the group interrupt is raised, the engine walks both levels through a request/acknowledge register-read port. For every pending bit it finds, it puts a vector number on a valid/ready output stream.

The vector number is rebuilt from the group, the index register and the bit position. The engine then folds it down to a canonical base that is shared by all CPUs, by clearing the low bits selected by the configured CPU count. Once the engine's local copy of the summary is empty, it reads the summary again, so that messages which arrived during the scan are not lost. It ends the pass only when a fresh summary read returns nothing pending, and it marks the end with a one-cycle done pulse.

Top module: `pend_vec_scan`

## Requirements
- R1: The reset `rst_ni` is asynchronous and active low. From any state it returns the engine to idle, with `rd_req_o`, `vec_valid_o` and `done_o` all low.
- R2: The engine stays idle, with no read request, until `grp_irq_i` is high at a clock edge. Its first read is then a summary read (`rd_sum_o` = 1). A read request and its selects stay unchanged until `rd_ack_i`, and `rd_data_i` is captured in the acknowledge cycle.
- R3: Summary bit i means that index register i is pending. Index registers are read (`rd_sum_o` = 0, `rd_idx_o` = i) in ascending order of the summary bits.
- R4: Each selected index register is read exactly once per selection. The vectors for its set bits are emitted from the lowest bit position to the highest.
- R5: Before reduction, the vector for bit b of index register i in group g (`grp_id_i`) is ((i*16)+b)*16+g.
- R6: `ncpu_i` holds 1, 2, 4, 8 or 16. The emitted vector is the R5 value with its low log2(`ncpu_i`) bits cleared.
- R7: After the last pending index register in the local summary copy has been serviced, the summary is read again. The scan goes on if that read shows pending bits, and it finishes only on a read that shows none.
- R8: While `vec_ready_i` is low, `vec_valid_o` stays high and `vec_o` stays unchanged. A vector is transferred in a cycle where both are high.
- R9: `done_o` is high for exactly one cycle, in the first idle cycle after the final empty summary read. In that cycle no read and no vector is presented.
- R10: An index register read whose low 16 data bits are zero emits no vector, and the scan moves on to the next pending index register.
- R11: Summary data bits 8 and above, and index data bits 16 and above, are ignored. A summary read that has only such bits set counts as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grp_irq_i | input | 1 | Group interrupt; starts a scan from idle |
| grp_id_i | input | 4 | Number of the serviced group |
| ncpu_i | input | 5 | CPU count (1, 2, 4, 8 or 16) |
| rd_req_o | output | 1 | Register read request |
| rd_sum_o | output | 1 | 1: summary register, 0: index register |
| rd_idx_o | output | 3 | Index register number for an index read |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | 32 | Read data |
| vec_valid_o | output | 1 | Vector stream valid |
| vec_ready_i | input | 1 | Vector stream ready |
| vec_o | output | 11 | Canonical vector number |
| done_o | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The bench runs several register images through the scan. These include an empty bank, a single bit, sparse bits spread across distant index registers, one bit in every register, and a fully set register next to a top-bit-only register. Each image tells apart a different error: wrong scan order, wrong vector arithmetic, or wrong canonical masking for each CPU count. A late injection into an index register that has already been serviced, and one into a lower index register, separate a correct summary reread from a scan that stops early. Upper-bit noise on both register levels, uneven ready patterns and a reset in the middle of a scan cover the ignored-bit, backpressure and recovery rules.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SUM_RD = 2'd1,
    ST_IDX_RD = 2'd2,
    ST_EMIT   = 2'd3
  } scan_st_e;
endpackage

// File: rtl/pvs_lsb_pick.sv
module pvs_lsb_pick #(
  parameter  int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // highest-to-lowest walk so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pvs_vec_build.sv
module pvs_vec_build #(
  parameter  int NUM_IDX  = 8,
  parameter  int IDX_BITS = 16,
  parameter  int NUM_GRP  = 16,
  parameter  int MAX_CPU  = 16,
  localparam int IDX_W    = $clog2(NUM_IDX),
  localparam int BIT_W    = $clog2(IDX_BITS),
  localparam int GRP_W    = $clog2(NUM_GRP),
  localparam int CPU_W    = $clog2(MAX_CPU) + 1,
  localparam int VEC_W    = $clog2(NUM_IDX * IDX_BITS * NUM_GRP)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [CPU_W-1:0] ncpu_i,
  output logic [VEC_W-1:0] vec_o
);
  localparam bit POW2 = (NUM_IDX == (1 << IDX_W)) && (IDX_BITS == (1 << BIT_W)) &&
                        (NUM_GRP == (1 << GRP_W));

  logic [VEC_W-1:0] raw;
  logic [VEC_W-1:0] keep;

  generate
    if (POW2) begin : g_concat
      assign raw = {idx_i, bit_i, grp_i};
    end else begin : g_arith
      assign raw = ((VEC_W'(idx_i) * VEC_W'(IDX_BITS)) + VEC_W'(bit_i)) * VEC_W'(NUM_GRP)
                   + VEC_W'(grp_i);
    end
  endgenerate

  // ncpu is a power of two, so modulo is a low-bit mask
  assign keep  = ~(VEC_W'(ncpu_i) - VEC_W'(1));
  assign vec_o = raw & keep;
endmodule

// File: rtl/pend_vec_scan.sv
module pend_vec_scan #(
  parameter  int NUM_IDX  = 8,
  parameter  int IDX_BITS = 16,
  parameter  int NUM_GRP  = 16,
  parameter  int MAX_CPU  = 16,
  parameter  int DATA_W   = 32,
  localparam int IDX_W    = $clog2(NUM_IDX),
  localparam int BIT_W    = $clog2(IDX_BITS),
  localparam int GRP_W    = $clog2(NUM_GRP),
  localparam int CPU_W    = $clog2(MAX_CPU) + 1,
  localparam int VEC_W    = $clog2(NUM_IDX * IDX_BITS * NUM_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_irq_i,
  input  logic [GRP_W-1:0]  grp_id_i,
  input  logic [CPU_W-1:0]  ncpu_i,
  output logic              rd_req_o,
  output logic              rd_sum_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              done_o
);
  import pvs_pkg::*;

  scan_st_e            state_q, state_d;
  logic [NUM_IDX-1:0]  sum_q, sum_d;
  logic [IDX_BITS-1:0] bits_q, bits_d;
  logic                done_q, done_d;

  logic [IDX_W-1:0]    sum_idx;
  logic [BIT_W-1:0]    bit_idx;
  logic [NUM_IDX-1:0]  sum_clr;
  logic [IDX_BITS-1:0] bits_clr;
  logic [NUM_IDX-1:0]  rd_sum_bits;
  logic [IDX_BITS-1:0] rd_idx_bits;
  logic                unused_rd_data;

  assign rd_sum_bits    = rd_data_i[NUM_IDX-1:0];
  assign rd_idx_bits    = rd_data_i[IDX_BITS-1:0];
  assign unused_rd_data = ^rd_data_i;

  // drop lowest set bit
  assign sum_clr  = sum_q & (sum_q - NUM_IDX'(1));
  assign bits_clr = bits_q & (bits_q - IDX_BITS'(1));

  pvs_lsb_pick #(.W(NUM_IDX)) u_sum_pick (
    .vec_i (sum_q),
    .idx_o (sum_idx)
  );

  pvs_lsb_pick #(.W(IDX_BITS)) u_bit_pick (
    .vec_i (bits_q),
    .idx_o (bit_idx)
  );

  pvs_vec_build #(
    .NUM_IDX  (NUM_IDX),
    .IDX_BITS (IDX_BITS),
    .NUM_GRP  (NUM_GRP),
    .MAX_CPU  (MAX_CPU)
  ) u_vec_build (
    .idx_i  (sum_idx),
    .bit_i  (bit_idx),
    .grp_i  (grp_id_i),
    .ncpu_i (ncpu_i),
    .vec_o  (vec_o)
  );

  always_comb begin
    state_d = state_q;
    sum_d   = sum_q;
    bits_d  = bits_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (grp_irq_i) state_d = ST_SUM_RD;
      end
      ST_SUM_RD: begin
        if (rd_ack_i) begin
          sum_d = rd_sum_bits;
          if (rd_sum_bits == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_IDX_RD;
          end
        end
      end
      ST_IDX_RD: begin
        if (rd_ack_i) begin
          bits_d = rd_idx_bits;
          if (rd_idx_bits == '0) begin
            sum_d   = sum_clr;
            state_d = (sum_clr == '0) ? ST_SUM_RD : ST_IDX_RD;
          end else begin
            state_d = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (vec_ready_i) begin
          bits_d = bits_clr;
          if (bits_clr == '0) begin
            sum_d   = sum_clr;
            state_d = (sum_clr == '0) ? ST_SUM_RD : ST_IDX_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sum_q   <= '0;
      bits_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sum_q   <= sum_d;
      bits_q  <= bits_d;
      done_q  <= done_d;
    end
  end

  assign rd_req_o    = (state_q == ST_SUM_RD) || (state_q == ST_IDX_RD);
  assign rd_sum_o    = (state_q == ST_SUM_RD);
  assign rd_idx_o    = sum_idx;
  assign vec_valid_o = (state_q == ST_EMIT);
  assign done_o      = done_q;
endmodule

// File: rtl/pvs_scan_chk.sv
module pvs_scan_chk #(
  parameter int IDX_W = 3,
  parameter int CPU_W = 5,
  parameter int VEC_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CPU_W-1:0] ncpu_i,
  input logic             rd_req_o,
  input logic             rd_sum_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             rd_ack_i,
  input logic             vec_valid_o,
  input logic             vec_ready_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             done_o
);
  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_o));

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_sum_o) && $stable(rd_idx_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o && !vec_valid_o);

  // R6
  canon_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ((vec_o & VEC_W'(ncpu_i - CPU_W'(1))) == '0));

  // R4
  rd_emit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && vec_valid_o));
endmodule

bind pend_vec_scan pvs_scan_chk #(
  .IDX_W (IDX_W),
  .CPU_W (CPU_W),
  .VEC_W (VEC_W)
) u_pvs_scan_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ncpu_i      (ncpu_i),
  .rd_req_o    (rd_req_o),
  .rd_sum_o    (rd_sum_o),
  .rd_idx_o    (rd_idx_o),
  .rd_ack_i    (rd_ack_i),
  .vec_valid_o (vec_valid_o),
  .vec_ready_i (vec_ready_i),
  .vec_o       (vec_o),
  .done_o      (done_o)
);

// File: tb/pend_vec_scan_bench.sv
`timescale 1ns/1ps
module pend_vec_scan_bench;
  localparam int GRP_W = 4, CPU_W = 5, IDX_W = 3, VEC_W = 11, DATA_W = 32;

  typedef struct packed {
    logic [3:0]       grp;
    logic [4:0]       ncpu;
    logic [7:0]       rdy;
    logic [31:0]      junk;
    logic [2:0]       late_idx;
    logic [15:0]      late_bits;
    logic [7:0][31:0] mem;
  } case_t;

  localparam int NCASE = 7;
  localparam case_t CASES [NCASE] = '{
    '{4'd0,  5'd1,  8'hFF, 32'h0,    3'd0, 16'h0,
      {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0}},
    '{4'd3,  5'd1,  8'hFF, 32'h0,    3'd0, 16'h0,
      {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1}},
    '{4'd5,  5'd4,  8'hA6, 32'h0,    3'd2, 16'h0100,
      {32'h10, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8001, 32'h0, 32'h0}},
    '{4'd15, 5'd16, 8'h5B, 32'h0,    3'd0, 16'h0002,
      {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFF, 32'h0}},
    '{4'd10, 5'd8,  8'hFF, 32'hFF00, 3'd0, 16'h0,
      {32'h0, 32'h0, 32'h0, 32'h400, 32'h0001_0000, 32'h0, 32'h0, 32'h0}},
    '{4'd0,  5'd2,  8'h0F, 32'h0,    3'd0, 16'h0,
      {32'h4000, 32'h1000, 32'h400, 32'h100, 32'h40, 32'h10, 32'h4, 32'h1}},
    '{4'd9,  5'd2,  8'hFF, 32'h0,    3'd0, 16'h0,
      {32'h0, 32'hFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8000}}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              grp_irq_i = 1'b0;
  logic [GRP_W-1:0]  grp_id_i = '0;
  logic [CPU_W-1:0]  ncpu_i = 5'd1;
  logic              rd_ack_i = 1'b0;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic              vec_ready_i = 1'b0;
  logic              rd_req_o, rd_sum_o, vec_valid_o, done_o;
  logic [IDX_W-1:0]  rd_idx_o;
  logic [VEC_W-1:0]  vec_o;

  pend_vec_scan u_pend_vec_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grp_irq_i   (grp_irq_i),
    .grp_id_i    (grp_id_i),
    .ncpu_i      (ncpu_i),
    .rd_req_o    (rd_req_o),
    .rd_sum_o    (rd_sum_o),
    .rd_idx_o    (rd_idx_o),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .vec_valid_o (vec_valid_o),
    .vec_ready_i (vec_ready_i),
    .vec_o       (vec_o),
    .done_o      (done_o)
  );

  always #2.5 clk_i = ~clk_i;

  // bank model and stream sink state
  logic [31:0]      mem [8];
  logic [31:0]      junk_sum = '0;
  logic [7:0]       rdy_pat = 8'hFF;
  logic [2:0]       late_idx = '0;
  logic [15:0]      late_bits = '0;
  int               phase = 0;
  int               n_sum = 0, n_idx = 0, n_got = 0, n_done = 0, stall_err = 0;
  int               got [256];
  logic             stall_pend = 1'b0;
  logic [VEC_W-1:0] stall_vec = '0;

  int               n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = '0;
    forever begin
      @(negedge clk_i);
      if (rd_ack_i) begin
        rd_ack_i = 1'b0;
      end else if (rd_req_o) begin
        rd_ack_i = 1'b1;
        if (rd_sum_o) begin
          logic [31:0] s;
          s = junk_sum;
          for (int i = 0; i < 8; i++) if (mem[i] != '0) s[i] = 1'b1;
          rd_data_i = s;
          n_sum++;
        end else begin
          rd_data_i = mem[rd_idx_o];
          mem[rd_idx_o] = '0;
          n_idx++;
        end
      end
      vec_ready_i = rdy_pat[phase % 8];
      phase++;
      if (stall_pend && (!vec_valid_o || vec_o != stall_vec)) stall_err++;
      stall_pend = vec_valid_o && !vec_ready_i;
      stall_vec  = vec_o;
      if (vec_valid_o && vec_ready_i) begin
        if (n_got < 256) got[n_got] = int'(vec_o);
        n_got++;
        if (n_got == 1 && late_bits != '0) mem[late_idx] = mem[late_idx] | {16'h0, late_bits};
      end
      if (done_o) n_done++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic clear_counts();
    n_sum = 0; n_idx = 0; n_got = 0; n_done = 0; stall_err = 0;
  endtask

  task automatic run_case(input case_t c, input int cn);
    int exp [256];
    int n_exp;
    int idx_exp;
    int sum_exp;
    @(negedge clk_i);
    grp_id_i  = c.grp;
    ncpu_i    = c.ncpu;
    rdy_pat   = c.rdy;
    junk_sum  = c.junk;
    late_idx  = c.late_idx;
    late_bits = c.late_bits;
    for (int i = 0; i < 8; i++) mem[i] = c.mem[i];
    n_exp = 0;
    idx_exp = 0;
    for (int i = 0; i < 8; i++) begin
      if (c.mem[i] != '0) idx_exp++;
      for (int b = 0; b < 16; b++)
        if (c.mem[i][b]) begin
          exp[n_exp] = ((((i * 16) + b) * 16) + int'(c.grp)) & ~(int'(c.ncpu) - 1);
          n_exp++;
        end
    end
    if (c.late_bits != '0) begin
      for (int b = 0; b < 16; b++)
        if (c.late_bits[b]) begin
          exp[n_exp] = ((((int'(c.late_idx) * 16) + b) * 16) + int'(c.grp)) & ~(int'(c.ncpu) - 1);
          n_exp++;
        end
      idx_exp++;
      sum_exp = 3;
    end else begin
      sum_exp = (idx_exp == 0) ? 1 : 2;
    end
    clear_counts();
    grp_irq_i = 1'b1;
    @(negedge clk_i);
    grp_irq_i = 1'b0;
    for (int k = 0; k < 4000 && n_done == 0; k++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    // R3/R4/R5/R6 vector order and value
    check(n_got == n_exp, $sformatf("R3/R4 case %0d vector count", cn), n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++)
      check(got[k] == exp[k], $sformatf("R5/R6 case %0d vector %0d", cn, k), got[k], exp[k]);
    // R4/R10 each pending index register read once
    check(n_idx == idx_exp, $sformatf("R4/R10 case %0d index reads", cn), n_idx, idx_exp);
    // R7/R11 summary rereads and upper-bit noise
    check(n_sum == sum_exp, $sformatf("R7/R11 case %0d summary reads", cn), n_sum, sum_exp);
    // R9 single done pulse
    check(n_done == 1, $sformatf("R9 case %0d done pulses", cn), n_done, 1);
    // R8 held under backpressure
    check(stall_err == 0, $sformatf("R8 case %0d stall changes", cn), stall_err, 0);
    check(!rd_req_o && !vec_valid_o, $sformatf("R9 case %0d idle after done", cn),
          int'(rd_req_o) + int'(vec_valid_o), 0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(!rd_req_o && !vec_valid_o && !done_o, "R1 reset outputs",
          int'(rd_req_o) + int'(vec_valid_o) + int'(done_o), 0);
    rst_ni = 1'b1;

    // R2 no scan without the group interrupt
    @(negedge clk_i);
    mem[5] = 32'h1;
    clear_counts();
    repeat (20) @(negedge clk_i);
    check(n_sum == 0 && n_idx == 0 && !rd_req_o, "R2 idle without irq", n_sum + n_idx, 0);
    mem[5] = '0;

    // R2 first read after irq is the summary
    @(negedge clk_i);
    mem[1] = 32'h2;
    grp_irq_i = 1'b1;
    @(negedge clk_i);
    grp_irq_i = 1'b0;
    check(rd_req_o && rd_sum_o, "R2 first read is summary", int'(rd_sum_o), 1);
    for (int k = 0; k < 200 && n_done == 0; k++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 8; i++) mem[i] = '0;

    for (int c = 0; c < NCASE; c++) run_case(CASES[c], c);
    junk_sum = '0;
    late_bits = '0;

    // R1 reset in the middle of a stalled scan
    @(negedge clk_i);
    rdy_pat = 8'h00;
    grp_id_i = 4'd2;
    ncpu_i = 5'd1;
    mem[3] = 32'h0F0F;
    grp_irq_i = 1'b1;
    @(negedge clk_i);
    grp_irq_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check(vec_valid_o, "R8 stalled vector held", int'(vec_valid_o), 1);
    #1 rst_ni = 1'b0;
    #0.5;
    check(!rd_req_o && !vec_valid_o && !done_o, "R1 async reset mid-scan",
          int'(rd_req_o) + int'(vec_valid_o) + int'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rdy_pat = 8'hFF;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    clear_counts();
    repeat (8) @(negedge clk_i);
    check(n_sum == 0 && n_got == 0 && !rd_req_o, "R1 idle after reset", n_sum + n_got, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule